// File: doc/BRIEF.md
# Sequencer Register Bank with Pin Diagnostics

This block holds the two register rows of a registered logic sequencer: a state row, whose value is fed back to external next-state logic, and an output row, whose value normally appears on a shared 8-bit pin bus. Both rows take their next values from combinational logic that sits outside the block. The pin bus is split into an input, an output and one drive enable, so that a pad ring or a board model can build the bidirectional pin from them.

Three diagnostic selects give test access through the same pins. One shows the state row on the pins. One loads the state row from the pins. One loads the output row from the pins. In each mode the row that is not selected keeps its value. By parameter, the low nibble of both rows can run on one clock and the high nibble on a second clock. When the second clock pin is not used as a clock, it is passed out as a plain logic term. A shared control pin works either as an asynchronous initialization input, with a preset or reset value chosen per bit, or as an active-low output enable.

There is no streaming data path, so all ports are plain level or clock signals with no handshake and no back-pressure.

Top module: `sqb_regbank`

## Requirements
- R1: In run mode (no diagnostic select active), a rising clock edge loads `state_next` into the state row and `out_next` into the output row. `pad_out` shows the output row and `pad_drive_en` is 1.
- R2: With `diag_peek` alone active, `pad_out` shows the state row and `pad_drive_en` is 1. The state row still loads `state_next`, and the output row holds its value.
- R3: With `diag_load_p` active, `pad_drive_en` is 0 and a rising edge copies `pad_in` into the state row. The output row holds its value.
- R4: With `diag_load_q` active, `pad_drive_en` is 0 and a rising edge copies `pad_in` into the output row. The state row holds its value.
- R5: When several selects are active, `diag_load_q` wins over `diag_load_p`, and `diag_load_p` wins over `diag_peek`.
- R6: With `SPLIT_CLK`=1, `clk_a` clocks bits 3:0 of both rows and `clk_b_in` clocks bits 7:4. `aux_term` is 0.
- R7: With `SPLIT_CLK`=0, `clk_a` clocks all bits, `clk_b_in` clocks nothing, and `aux_term` follows `clk_b_in`.
- R8: With `USE_INIT`=1, a high `init_oe` forces the state row to `P_INIT` (default 8'hA5) and the output row to `Q_INIT` (default 8'h3C) at once, without waiting for a clock. Clock edges have no effect while it stays high.
- R9: After `init_oe` falls, a row nibble ignores every rising edge of its clock until that clock has had a falling edge.
- R10: With `USE_INIT`=0, `init_oe` is an active-low output enable. In run mode `pad_drive_en` equals its inverse, and a high level does not change either row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Clock for all bits, or for the low nibble when the clock is split |
| clk_b_in | input | 1 | High-nibble clock when split; otherwise a plain logic input |
| init_oe | input | 1 | Initialization (active high) or output enable (active low), chosen by parameter |
| diag_peek | input | 1 | Show the state row on the pins |
| diag_load_p | input | 1 | Load the state row from the pins |
| diag_load_q | input | 1 | Load the output row from the pins |
| state_next | input | W | Next state value from the external logic |
| out_next | input | W | Next output value from the external logic |
| pad_in | input | W | Value present on the pins |
| pad_out | output | W | Value driven onto the pins |
| pad_drive_en | output | 1 | 1 when the block drives the pins |
| state_q | output | W | State row, fed back to the next-state logic |
| aux_term | output | 1 | `clk_b_in` as a logic term, or 0 when it is used as a clock |

## Verification
A wrong mode decode shows at the pins right away, before any clock edge. The drive enable or the pin value is wrong in the same cycle that the selects change. A row that takes a load meant for the other row shows one edge later, as a state value on `state_q` or as an output value on `pad_out` once run mode returns. An error in the restart gate or in the nibble clock routing shows within two edges after release or after the second clock stops, because only part of a word updates. A wrong initialization value shows as soon as `init_oe` rises.

// File: rtl/sqb_pkg.sv
`timescale 1ns/1ps
package sqb_pkg;
  typedef enum logic [1:0] {
    MODE_RUN    = 2'd0,
    MODE_PEEK   = 2'd1,
    MODE_LOAD_P = 2'd2,
    MODE_LOAD_Q = 2'd3
  } diag_mode_e;
endpackage

// File: rtl/sqb_mode_decode.sv
`timescale 1ns/1ps
module sqb_mode_decode
  import sqb_pkg::*;
(
  input  logic       peek_req,
  input  logic       load_p_req,
  input  logic       load_q_req,
  output diag_mode_e mode
);
  // Fixed priority: output-row load, then state-row load, then peek (R5)
  always_comb begin
    if (load_q_req)      mode = MODE_LOAD_Q;
    else if (load_p_req) mode = MODE_LOAD_P;
    else if (peek_req)   mode = MODE_PEEK;
    else                 mode = MODE_RUN;
  end
endmodule

// File: rtl/sqb_nibble_bank.sv
`timescale 1ns/1ps
module sqb_nibble_bank
  import sqb_pkg::*;
#(
  parameter int          NW     = 4,
  parameter logic [NW-1:0] P_INIT = '0,
  parameter logic [NW-1:0] Q_INIT = '0
) (
  input  logic          clk,
  input  logic          init_act,
  input  diag_mode_e    mode,
  input  logic [NW-1:0] p_next,
  input  logic [NW-1:0] q_next,
  input  logic [NW-1:0] pad_in,
  output logic [NW-1:0] p_q,
  output logic [NW-1:0] q_q,
  output logic          armed
);
  logic [NW-1:0] p_d;
  logic [NW-1:0] q_d;

  // Restart gate: cleared by init, set by the first falling clock edge (R9)
  always_ff @(negedge clk or posedge init_act) begin
    if (init_act) armed <= 1'b0;
    else          armed <= 1'b1;
  end

  always_comb begin
    p_d = p_next;
    q_d = q_next;
    unique case (mode)
      MODE_RUN:    begin p_d = p_next; q_d = q_next; end
      MODE_PEEK:   begin p_d = p_next; q_d = q_q;    end
      MODE_LOAD_P: begin p_d = pad_in; q_d = q_q;    end
      MODE_LOAD_Q: begin p_d = p_q;    q_d = pad_in; end
      default:     begin p_d = p_q;    q_d = q_q;    end
    endcase
  end

  always_ff @(posedge clk or posedge init_act) begin
    if (init_act) begin
      p_q <= P_INIT;
      q_q <= Q_INIT;
    end else if (armed) begin
      p_q <= p_d;
      q_q <= q_d;
    end
  end
endmodule

// File: rtl/sqb_pad_mux.sv
`timescale 1ns/1ps
module sqb_pad_mux
  import sqb_pkg::*;
#(
  parameter int W        = 8,
  parameter bit USE_INIT = 1'b1
) (
  input  diag_mode_e   mode,
  input  logic [W-1:0] p_row,
  input  logic [W-1:0] q_row,
  input  logic         oe_n,
  output logic [W-1:0] pad_out,
  output logic         drive_en
);
  logic run_en;

  generate
    if (USE_INIT) begin : g_always_on
      assign run_en = 1'b1;
    end else begin : g_oe_pin
      assign run_en = ~oe_n;
    end
  endgenerate

  always_comb begin
    unique case (mode)
      MODE_PEEK:   begin pad_out = p_row; drive_en = 1'b1;   end
      MODE_LOAD_P,
      MODE_LOAD_Q: begin pad_out = q_row; drive_en = 1'b0;   end
      default:     begin pad_out = q_row; drive_en = run_en; end
    endcase
  end
endmodule

// File: rtl/sqb_regbank.sv
`timescale 1ns/1ps
module sqb_regbank
  import sqb_pkg::*;
#(
  parameter int          W         = 8,
  parameter int          NW        = 4,
  parameter bit          SPLIT_CLK = 1'b0,
  parameter bit          USE_INIT  = 1'b1,
  parameter logic [W-1:0] P_INIT   = 8'hA5,
  parameter logic [W-1:0] Q_INIT   = 8'h3C
) (
  input  logic         clk_a,
  input  logic         clk_b_in,
  input  logic         init_oe,
  input  logic         diag_peek,
  input  logic         diag_load_p,
  input  logic         diag_load_q,
  input  logic [W-1:0] state_next,
  input  logic [W-1:0] out_next,
  input  logic [W-1:0] pad_in,
  output logic [W-1:0] pad_out,
  output logic         pad_drive_en,
  output logic [W-1:0] state_q,
  output logic         aux_term
);
  localparam int NIB  = W / NW;
  localparam int HALF = NIB / 2;

  diag_mode_e     mode;
  logic           init_act;
  logic [W-1:0]   out_q;
  logic [NIB-1:0] nib_armed;

  assign init_act = USE_INIT ? init_oe : 1'b0;
  assign aux_term = SPLIT_CLK ? 1'b0 : clk_b_in;

  sqb_mode_decode u_dec (
    .peek_req   (diag_peek),
    .load_p_req (diag_load_p),
    .load_q_req (diag_load_q),
    .mode       (mode)
  );

  for (genvar n = 0; n < NIB; n++) begin : g_nib
    localparam bit ON_B = SPLIT_CLK && (NIB > 1) && (n >= HALF);
    logic nclk;
    assign nclk = ON_B ? clk_b_in : clk_a;

    sqb_nibble_bank #(
      .NW     (NW),
      .P_INIT (P_INIT[n*NW +: NW]),
      .Q_INIT (Q_INIT[n*NW +: NW])
    ) u_bank (
      .clk      (nclk),
      .init_act (init_act),
      .mode     (mode),
      .p_next   (state_next[n*NW +: NW]),
      .q_next   (out_next[n*NW +: NW]),
      .pad_in   (pad_in[n*NW +: NW]),
      .p_q      (state_q[n*NW +: NW]),
      .q_q      (out_q[n*NW +: NW]),
      .armed    (nib_armed[n])
    );
  end

  sqb_pad_mux #(.W(W), .USE_INIT(USE_INIT)) u_pad (
    .mode     (mode),
    .p_row    (state_q),
    .q_row    (out_q),
    .oe_n     (init_oe),
    .pad_out  (pad_out),
    .drive_en (pad_drive_en)
  );
endmodule

// File: rtl/sqb_regbank_chk.sv
`timescale 1ns/1ps
module sqb_regbank_chk
  import sqb_pkg::*;
#(
  parameter int          W      = 8,
  parameter int          NW     = 4,
  parameter logic [W-1:0] P_INIT = 8'hA5,
  parameter logic [W-1:0] Q_INIT = 8'h3C
) (
  input logic         clk_a,
  input logic         init_act,
  input logic         load_q_req,
  input diag_mode_e   mode,
  input logic [W-1:0] state_next,
  input logic [W-1:0] out_next,
  input logic [W-1:0] pad_in,
  input logic [W-1:0] pad_out,
  input logic         pad_drive_en,
  input logic [W-1:0] state_q,
  input logic [W-1:0] out_q,
  input logic         armed_lo
);
  logic seen = 1'b0;
  always_ff @(posedge clk_a) seen <= 1'b1;

  p_run_load_r1: assert property (@(posedge clk_a) disable iff (init_act || !seen)
    (mode == MODE_RUN && armed_lo) |=>
      (state_q[NW-1:0] == $past(state_next[NW-1:0]) && out_q[NW-1:0] == $past(out_next[NW-1:0])));

  p_peek_pins_r2: assert property (@(posedge clk_a) disable iff (init_act || !seen)
    (mode == MODE_PEEK) |-> (pad_out == state_q && pad_drive_en));

  p_load_p_copy_r3: assert property (@(posedge clk_a) disable iff (init_act || !seen)
    (mode == MODE_LOAD_P && armed_lo) |=>
      (state_q[NW-1:0] == $past(pad_in[NW-1:0]) && $stable(out_q[NW-1:0])));

  p_load_q_copy_r4: assert property (@(posedge clk_a) disable iff (init_act || !seen)
    (mode == MODE_LOAD_Q && armed_lo) |=>
      (out_q[NW-1:0] == $past(pad_in[NW-1:0]) && $stable(state_q[NW-1:0])));

  p_load_release_r5: assert property (@(posedge clk_a) disable iff (init_act || !seen)
    (mode == MODE_LOAD_P || mode == MODE_LOAD_Q) |-> !pad_drive_en);

  p_load_q_wins_r5: assert property (@(posedge clk_a) disable iff (!seen)
    load_q_req |-> (mode == MODE_LOAD_Q));

  p_init_force_r8: assert property (@(posedge clk_a) disable iff (!seen)
    init_act |-> (state_q == P_INIT && out_q == Q_INIT));

  p_restart_gate_r9: assert property (@(posedge clk_a) disable iff (init_act || !seen)
    !armed_lo |=> ($stable(state_q[NW-1:0]) && $stable(out_q[NW-1:0])));
endmodule

bind sqb_regbank sqb_regbank_chk #(
  .W(W), .NW(NW), .P_INIT(P_INIT), .Q_INIT(Q_INIT)
) u_chk (
  .clk_a        (clk_a),
  .init_act     (init_act),
  .load_q_req   (diag_load_q),
  .mode         (mode),
  .state_next   (state_next),
  .out_next     (out_next),
  .pad_in       (pad_in),
  .pad_out      (pad_out),
  .pad_drive_en (pad_drive_en),
  .state_q      (state_q),
  .out_q        (out_q),
  .armed_lo     (nib_armed[0])
);

// File: tb/test_sqb_regbank.sv
`timescale 1ns/1ps
module test_sqb_regbank;
  logic clk_a = 1'b0;
  logic clk_b_raw = 1'b0;
  logic b_run = 1'b1;
  logic clk_b;
  logic init_oe = 1'b1;
  logic peek = 1'b0, ldp = 1'b0, ldq = 1'b0;
  logic [7:0] snext = 8'h11, onext = 8'h22, pin = 8'h00;

  logic [7:0] m_pad, m_st, s_pad, s_st, o_pad, o_st;
  logic       m_de, s_de, o_de, m_aux, s_aux, o_aux;

  assign clk_b = clk_b_raw & b_run;
  always #2 clk_a = ~clk_a;                      // 250 MHz
  initial begin #1; forever #2 clk_b_raw = ~clk_b_raw; end

  sqb_regbank #(.SPLIT_CLK(1'b0), .USE_INIT(1'b1)) i_sqb_regbank (
    .clk_a(clk_a), .clk_b_in(clk_b), .init_oe(init_oe), .diag_peek(peek),
    .diag_load_p(ldp), .diag_load_q(ldq), .state_next(snext), .out_next(onext),
    .pad_in(pin), .pad_out(m_pad), .pad_drive_en(m_de), .state_q(m_st), .aux_term(m_aux));

  sqb_regbank #(.SPLIT_CLK(1'b1), .USE_INIT(1'b1)) i_sqb_regbank_split (
    .clk_a(clk_a), .clk_b_in(clk_b), .init_oe(init_oe), .diag_peek(peek),
    .diag_load_p(ldp), .diag_load_q(ldq), .state_next(snext), .out_next(onext),
    .pad_in(pin), .pad_out(s_pad), .pad_drive_en(s_de), .state_q(s_st), .aux_term(s_aux));

  sqb_regbank #(.SPLIT_CLK(1'b0), .USE_INIT(1'b0)) i_sqb_regbank_oe (
    .clk_a(clk_a), .clk_b_in(clk_b), .init_oe(init_oe), .diag_peek(peek),
    .diag_load_p(ldp), .diag_load_q(ldq), .state_next(snext), .out_next(onext),
    .pad_in(pin), .pad_out(o_pad), .pad_drive_en(o_de), .state_q(o_st), .aux_term(o_aux));

  typedef struct { string tag; int sel; logic [7:0] exp; } item_t;
  item_t sb_q[$];
  event  sample_ev;
  int    checks = 0, failures = 0;
  bit    done = 1'b0;

  function automatic logic [7:0] probe(int sel);
    case (sel)
      0: return m_st;   1: return m_pad;  2: return {7'd0, m_de};  3: return {7'd0, m_aux};
      4: return s_st;   5: return s_pad;  6: return {7'd0, s_de};  7: return {7'd0, s_aux};
      8: return o_st;   9: return o_pad;  10: return {7'd0, o_de};
      default: return {7'd0, o_aux};
    endcase
  endfunction

  // Driver side: push expectations, then release the monitor
  task automatic expect_v(string tag, int sel, logic [7:0] e);
    item_t it;
    it.tag = tag; it.sel = sel; it.exp = e;
    sb_q.push_back(it);
  endtask
  task automatic flush(); ->sample_ev; #0.1; endtask
  task automatic tick(); @(posedge clk_a); #1.5; endtask   // after both clock rises
  task automatic settle(); #0.5; endtask

  task automatic both(string tag, logic [7:0] st, logic [7:0] pad);
    expect_v(tag, 0, st); expect_v(tag, 1, pad);
    expect_v(tag, 4, st); expect_v(tag, 5, pad);
  endtask

  // Monitor side: pop and compare
  initial begin
    forever begin
      @(sample_ev);
      while (sb_q.size() > 0) begin
        item_t it;
        logic [7:0] act;
        it = sb_q.pop_front();
        act = probe(it.sel);
        checks++;
        if (act !== it.exp) begin
          failures++;
          $display("FAIL %s probe=%0d actual=%h expected=%h", it.tag, it.sel, act, it.exp);
        end
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R8: init held high blocks clocking
    tick(); tick();
    both("R8 init values", 8'hA5, 8'h3C);
    expect_v("R8 drive on", 2, 8'h01);
    expect_v("R10 oe high disables", 10, 8'h00);
    flush();
    // R9: release while both clocks are low; first rises must be ignored
    #1.9; init_oe = 1'b0;
    tick();
    both("R9 first edge ignored", 8'hA5, 8'h3C);
    flush();
    tick();
    both("R9 R1 resume after fall", 8'h11, 8'h22);
    expect_v("R10 oe low enables", 10, 8'h01);
    expect_v("R10 oe pins show Q", 9, 8'h22);
    flush();
    // R1 plus R6/R7 aux term
    snext = 8'h5A; onext = 8'hC3;
    tick();
    both("R1 run load", 8'h5A, 8'hC3);
    expect_v("R7 aux follows pin high", 3, 8'h01);
    expect_v("R6 aux zero when split", 7, 8'h00);
    flush();
    #1.9;
    expect_v("R7 aux follows pin low", 3, 8'h00);
    flush();
    snext = 8'hFF; onext = 8'h00;
    tick();
    both("R1 run load 2", 8'hFF, 8'h00);
    flush();
    // R6: stop second clock; split high nibble holds
    b_run = 1'b0; snext = 8'h12; onext = 8'h34;
    tick();
    expect_v("R7 single clock all bits", 0, 8'h12);
    expect_v("R7 single clock all bits", 1, 8'h34);
    expect_v("R6 low nibble only", 4, 8'hF2);
    expect_v("R6 low nibble only", 5, 8'h04);
    flush();
    #1.9; b_run = 1'b1;
    tick();
    both("R6 high nibble on clk_b", 8'h12, 8'h34);
    flush();
    // R3: load state row
    ldp = 1'b1; pin = 8'h9C; snext = 8'h77; onext = 8'h66;
    settle();
    expect_v("R3 pins released", 2, 8'h00);
    expect_v("R3 pins released", 6, 8'h00);
    flush();
    tick();
    expect_v("R3 state loaded", 0, 8'h9C);
    expect_v("R3 state loaded", 4, 8'h9C);
    flush();
    ldp = 1'b0; settle();
    expect_v("R3 output row held", 1, 8'h34);
    expect_v("R3 output row held", 5, 8'h34);
    flush();
    // R4: load output row
    ldq = 1'b1; pin = 8'hE1;
    tick();
    expect_v("R4 state row held", 0, 8'h9C);
    expect_v("R4 pins released", 2, 8'h00);
    flush();
    ldq = 1'b0; settle();
    expect_v("R4 output loaded", 1, 8'hE1);
    expect_v("R4 output loaded", 5, 8'hE1);
    flush();
    // R2: peek
    peek = 1'b1; snext = 8'h4B; onext = 8'h99;
    settle();
    expect_v("R2 pins show state", 1, 8'h9C);
    expect_v("R2 pins driven", 2, 8'h01);
    flush();
    tick();
    expect_v("R2 state still runs", 0, 8'h4B);
    expect_v("R2 pins show state", 5, 8'h4B);
    flush();
    peek = 1'b0; settle();
    expect_v("R2 output row held", 1, 8'hE1);
    flush();
    // R5: priority
    peek = 1'b1; ldp = 1'b1; ldq = 1'b1; pin = 8'hD2; snext = 8'h00;
    tick();
    expect_v("R5 load_q wins, state held", 0, 8'h4B);
    expect_v("R5 pins released", 2, 8'h00);
    flush();
    ldq = 1'b0; pin = 8'h6E;
    tick();
    expect_v("R5 load_p beats peek", 0, 8'h6E);
    expect_v("R5 pins released", 2, 8'h00);
    flush();
    ldp = 1'b0; settle();
    expect_v("R5 peek alone", 1, 8'h6E);
    expect_v("R5 peek alone drives", 2, 8'h01);
    flush();
    peek = 1'b0; settle();
    expect_v("R5 output from load_q", 1, 8'hD2);
    expect_v("R10 oe instance pins", 9, 8'hD2);
    flush();
    // R8: asynchronous force between edges
    init_oe = 1'b1; settle();
    both("R8 async force", 8'hA5, 8'h3C);
    expect_v("R10 no init in oe mode", 8, 8'h6E);
    expect_v("R10 oe off", 10, 8'h00);
    flush();
    snext = 8'h55; onext = 8'hAA;
    tick();
    both("R8 clock blocked", 8'hA5, 8'h3C);
    flush();
    // R9 again
    #1.9; init_oe = 1'b0;
    tick();
    both("R9 ignored again", 8'hA5, 8'h3C);
    flush();
    tick();
    both("R9 resumed again", 8'h55, 8'hAA);
    flush();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule